// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement State

This block holds the replacement state for every set of an 8-way set-associative cache and names, for each set, the way that should be overwritten on the next miss. Each set keeps seven direction bits arranged as a binary tree over the eight ways. To find a victim, the block walks the tree from the root and follows the branch each bit selects until it reaches a way. Every use of a way turns the bits on that way's path so that they point away from it. The result approximates least-recently-used order at a cost of seven bits per set.

The cache controller reports every hit with an access strobe, a set index and the way that hit. It reports a miss refill with a fill strobe and a set index. The block refills the way it currently names as victim for that set and counts that fill as a use of the way. The controller reads the current victim of any set through a lookup set index. The answer is combinational from the stored bits. Tag comparison and data storage stay in the surrounding cache.

Top module: `plru_array`

## Requirements
- R1: While reset is asserted, and right after it is released, every direction bit in every set is 0 and every set reports victim way 0.
- R2: The victim is found by a walk from the root. A node bit of 0 selects the lower-numbered half and 1 selects the upper half. The root decides victim bit [2], the second-level node decides bit [1] and the third-level node decides bit [0]. The nodes are numbered 0 at the root, 1 and 2 below it, and 3 to 6 at the third level. The children of node n are 2n+1 (lower half) and 2n+2 (upper half).
- R3: An access to way w sets each bit on the path from the root to w to the opposite of the branch toward w. The new victim is visible from the first clock edge after the strobe onward. From reset, accesses to ways 5, 0 and 7 of one set give victims 0, 6 and 2 in turn.
- R4: Bits not on the accessed path keep their values. In the R3 sequence, the access to way 7 leaves node 1 at 1, which is why the victim is 2 and not 0.
- R5: After an access to way w of a set, that set's victim is not w.
- R6: A fill refills the set's current victim and updates the tree exactly as an access to that way would. From reset, eight consecutive fills to one set use ways 0, 4, 2, 6, 1, 5, 3, 7 and so visit every way exactly once.
- R7: The victim of a set changes only on a clock edge after an access or fill to that same set. Strobes to other sets, and cycles with no strobe, leave it unchanged.
- R8: When an access and a fill name the same set in the same cycle, only the access updates that set and the fill is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset that clears all direction bits |
| acc_valid | input | 1 | A way of set acc_set was used this cycle |
| acc_set | input | 4 | Set index of the access |
| acc_way | input | 3 | Way index of the access |
| fill_valid | input | 1 | The current victim of fill_set is refilled this cycle |
| fill_set | input | 4 | Set index of the fill |
| look_set | input | 4 | Set whose victim is reported |
| victim_way | output | 3 | Current victim way of look_set |

## Verification
Two situations are hard to reach from the ports. The first is a same-cycle access and fill to one set. The bench first moves that set away from its reset state, so that the fill's victim and the accessed way give different trees. Only then does it raise both strobes together. The second is the preservation of bits off the accessed path, which can only be seen through the victim walk. A directed sequence of accesses sets a second-level bit and then touches a leaf in the other half. The following victim then depends on the preserved bit. A random phase mixes accesses and fills over all sets and compares each cycle against a behavioural model.

// File: rtl/plru_pkg.sv
package plru_pkg;

    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_ACCESS = 2'd1,
        UPD_FILL   = 2'd2
    } upd_src_e;

endpackage

// File: rtl/plru_victim_walk.sv
module plru_victim_walk #(
    parameter int WAYS = 8,
    localparam int LEVELS = $clog2(WAYS),
    localparam int NODES  = WAYS - 1
) (
    input  logic [NODES-1:0]  tree_i,
    output logic [LEVELS-1:0] victim_o
);

    logic [LEVELS-1:0] node;
    logic              dir;

    // Walk from the root; each level decides one victim bit, MSB first.
    always_comb begin
        victim_o = '0;
        node     = '0;
        dir      = 1'b0;
        for (int lvl = 0; lvl < LEVELS; lvl++) begin
            dir                       = tree_i[node];
            victim_o[LEVELS-1-lvl]    = dir;
            node = (node << 1) + LEVELS'(1) + LEVELS'(dir);
        end
    end

endmodule

// File: rtl/plru_path_update.sv
module plru_path_update #(
    parameter int WAYS = 8,
    localparam int LEVELS = $clog2(WAYS),
    localparam int NODES  = WAYS - 1
) (
    input  logic [NODES-1:0]  tree_i,
    input  logic [LEVELS-1:0] way_i,
    output logic [NODES-1:0]  tree_o
);

    logic [LEVELS-1:0] node;
    logic              dir;

    // Point every node on the path to way_i away from it; keep the rest.
    always_comb begin
        tree_o = tree_i;
        node   = '0;
        dir    = 1'b0;
        for (int lvl = 0; lvl < LEVELS; lvl++) begin
            dir          = way_i[LEVELS-1-lvl];
            tree_o[node] = ~dir;
            node = (node << 1) + LEVELS'(1) + LEVELS'(dir);
        end
    end

endmodule

// File: rtl/plru_set.sv
module plru_set
    import plru_pkg::*;
#(
    parameter int WAYS = 8,
    localparam int LEVELS = $clog2(WAYS),
    localparam int NODES  = WAYS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [LEVELS-1:0] acc_way,
    input  logic              fill_valid,
    output logic [LEVELS-1:0] victim_way
);

    typedef struct packed {
        logic [NODES-1:0] tree;
    } set_state_t;

    set_state_t        st_d, st_q;
    upd_src_e          src;
    logic [LEVELS-1:0] upd_way;
    logic [NODES-1:0]  tree_touched;
    logic [LEVELS-1:0] victim_now;

    plru_victim_walk #(.WAYS(WAYS)) u_walk (
        .tree_i   (st_q.tree),
        .victim_o (victim_now)
    );

    plru_path_update #(.WAYS(WAYS)) u_upd (
        .tree_i (st_q.tree),
        .way_i  (upd_way),
        .tree_o (tree_touched)
    );

    // An access outranks a fill in the same cycle; a fill uses the victim.
    always_comb begin
        if (acc_valid)       src = UPD_ACCESS;
        else if (fill_valid) src = UPD_FILL;
        else                 src = UPD_NONE;

        upd_way = (src == UPD_ACCESS) ? acc_way : victim_now;

        st_d = st_q;
        if (src != UPD_NONE) st_d.tree = tree_touched;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign victim_way = victim_now;

endmodule

// File: rtl/plru_array.sv
module plru_array #(
    parameter int NUM_SETS = 16,
    parameter int WAYS     = 8,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [WAY_W-1:0] acc_way,
    input  logic             fill_valid,
    input  logic [SET_W-1:0] fill_set,
    input  logic [SET_W-1:0] look_set,
    output logic [WAY_W-1:0] victim_way
);

    logic [WAY_W-1:0] set_victim [NUM_SETS];
    logic [WAY_W-1:0] fill_way_w;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic acc_hit;
        logic fill_hit;
        assign acc_hit  = acc_valid  && (acc_set  == SET_W'(s));
        assign fill_hit = fill_valid && (fill_set == SET_W'(s));

        plru_set #(.WAYS(WAYS)) u_set (
            .clk        (clk),
            .rst_n      (rst_n),
            .acc_valid  (acc_hit),
            .acc_way    (acc_way),
            .fill_valid (fill_hit),
            .victim_way (set_victim[s])
        );
    end

    assign victim_way = set_victim[look_set];
    assign fill_way_w = set_victim[fill_set];

endmodule

// File: rtl/plru_array_chk.sv
module plru_array_chk #(
    parameter int NUM_SETS = 16,
    parameter int WAYS     = 8,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic [SET_W-1:0] acc_set,
    input logic [WAY_W-1:0] acc_way,
    input logic             fill_valid,
    input logic [SET_W-1:0] fill_set,
    input logic [SET_W-1:0] look_set,
    input logic [WAY_W-1:0] victim_way,
    input logic [WAY_W-1:0] fill_way_w
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> victim_way == '0);

    // R5
    mru_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (look_set != $past(acc_set) || victim_way != $past(acc_way)));

    // R6
    fill_moves_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !(acc_valid && acc_set == fill_set))
        |=> (look_set != $past(fill_set) || victim_way != $past(fill_way_w)));

    // R7
    quiet_set_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(acc_valid && acc_set == look_set) && !(fill_valid && fill_set == look_set))
        |=> (look_set != $past(look_set) || $stable(victim_way)));

endmodule

bind plru_array plru_array_chk #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) u_chk (.*);

// File: tb/tb_plru_array.sv
module tb_plru_array;

    localparam int CLK_PERIOD = 10;
    localparam int NSETS = 16;
    localparam int LEV   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [3:0] acc_set = '0;
    logic [2:0] acc_way = '0;
    logic       fill_valid = 1'b0;
    logic [3:0] fill_set = '0;
    logic [3:0] look_set = '0;
    logic [2:0] victim_way;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural model: seven direction bits per set held in plain integers.
    int mdl [NSETS][7];

    plru_array dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_way(acc_way), .fill_valid(fill_valid), .fill_set(fill_set),
        .look_set(look_set), .victim_way(victim_way)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int m_victim(int s);
        int n = 0;
        int w = 0;
        for (int l = 0; l < LEV; l++) begin
            int b = mdl[s][n];
            w = w * 2 + b;
            n = 2 * n + 1 + b;
        end
        return w;
    endfunction

    function automatic void m_touch(int s, int w);
        int n = 0;
        for (int l = 0; l < LEV; l++) begin
            int d = (w >> (LEV - 1 - l)) & 1;
            mdl[s][n] = (d == 0) ? 1 : 0;
            n = 2 * n + 1 + d;
        end
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; drives strobes over one rising edge and
    // returns at the next falling edge with strobes released.
    task automatic step(bit av, int as, int aw, bit fv, int fs, int ls);
        int fvw;
        acc_valid = av; acc_set = 4'(as); acc_way = 3'(aw);
        fill_valid = fv; fill_set = 4'(fs); look_set = 4'(ls);
        @(posedge clk);
        fvw = m_victim(fs);
        if (av) m_touch(as, aw);
        if (fv && !(av && as == fs)) m_touch(fs, fvw);
        @(negedge clk);
        acc_valid = 1'b0; fill_valid = 1'b0;
    endtask

    task automatic peek(int s, output int v);
        look_set = 4'(s);
        #1;
        v = int'(victim_way);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int v;
        int seen;
        for (int s = 0; s < NSETS; s++)
            for (int n = 0; n < 7; n++) mdl[s][n] = 0;

        repeat (3) @(posedge clk);
        // R1: victim is 0 while in reset
        peek(7, v); check(v == 0, "R1 in reset", v, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NSETS; s++) begin
            peek(s, v); check(v == 0, "R1 after reset", v, 0);
        end

        // R3 / R4 on set 3: ways 5, 0, 7 -> victims 0, 6, 2
        @(negedge clk);
        step(1, 3, 5, 0, 0, 3);
        check(victim_way == 3'd0, "R3 after way 5", int'(victim_way), 0);
        step(1, 3, 0, 0, 0, 3);
        check(victim_way == 3'd6, "R3 after way 0", int'(victim_way), 6);
        step(1, 3, 7, 0, 0, 3);
        check(victim_way == 3'd2, "R4 off-path bit kept", int'(victim_way), 2);
        check(victim_way != 3'd7, "R5 not last way", int'(victim_way), 7);

        // R6: eight fills to set 2 -> 0,4,2,6,1,5,3,7, each way once
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            int exp_seq[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
            peek(2, v);
            check(v == exp_seq[i], "R6 fill order", v, exp_seq[i]);
            check(((seen >> v) & 1) == 0, "R6 way revisited", v, -1);
            seen = seen | (1 << v);
            step(0, 0, 0, 1, 2, 2);
            check(int'(victim_way) != v, "R6 victim moved", int'(victim_way), v);
        end
        check(seen == 255, "R6 all ways used", seen, 255);

        // R8: set 5, access way 0 then access way 1 plus fill together
        step(1, 5, 0, 0, 0, 5);
        check(victim_way == 3'd4, "R8 setup", int'(victim_way), 4);
        step(1, 5, 1, 1, 5, 5);
        check(victim_way == 3'd4, "R8 access wins over fill", int'(victim_way), 4);

        // R7: set 6 never touched, unchanged by all of the above
        peek(6, v); check(v == 0, "R7 other set untouched", v, 0);
        step(0, 0, 0, 0, 0, 3);
        check(victim_way == 3'd2, "R7 idle cycle", int'(victim_way), 2);

        // Random mix over all sets, compared every cycle (R2, R5, R7)
        for (int i = 0; i < 2000; i++) begin
            bit av = ($urandom % 3) != 0;
            bit fv = ($urandom % 3) == 0;
            int as = (($urandom % 4) == 0) ? 9 : int'($urandom % NSETS);
            int aw = int'($urandom % 8);
            int fs = (($urandom % 2) == 0) ? as : int'($urandom % NSETS);
            int ls = (($urandom % 4) == 0) ? int'($urandom % NSETS) : as;
            step(av, as, aw, fv, fs, ls);
            check(int'(victim_way) == m_victim(ls), "R2 model match",
                  int'(victim_way), m_victim(ls));
            if (av && ls == as)
                check(int'(victim_way) != aw, "R5 random mru", int'(victim_way), aw);
        end
        for (int s = 0; s < NSETS; s++) begin
            peek(s, v);
            check(v == m_victim(s), "R7 final per-set state", v, m_victim(s));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule